// File: doc/BRIEF.md
# Register-Controlled Seven-Segment Digit Driver

This block is a bus-attached peripheral that lights one seven-segment digit. A processor reaches it over a simple synchronous slave port with a chip select, a one-bit word address, separate read and write strobes and 32-bit data in each direction. Two word-sized registers make up its map. The digit register at word 0 holds a small value to show. The control register at word 1 holds a single enable flag that either shows that value or blanks the digit.

Software writes the digit and then sets the enable flag. It can read either register back at any time. The segment pins are active-low and registered, so they change cleanly one clock after a register update. Read data is also registered and appears on the cycle after the read strobe.

Top module: `seg_display_ctrl`

## Requirements
- R1: After reset the digit and control registers are 0, `seg_n` is 7'h7F (all segments off) and `rd_data` is 0.
- R2: A register changes only on a clock edge where `cs` and `wr` are both 1. A write strobe without chip select has no effect on either register or on `seg_n`.
- R3: A write to word 0 stores `wr_data[2:0]` as the digit. A write to word 1 stores `wr_data[0]` as the enable flag. All higher write bits are dropped.
- R4: When `cs` and `rd` are both 1 at a clock edge, `rd_data` holds the addressed register zero-extended to 32 bits from that edge until the next one (word 0 gives the digit in bits 2:0, word 1 gives the flag in bit 0).
- R5: After any clock edge without an accepted read (`cs` and `rd` not both 1), `rd_data` is 0.
- R6: A read and a write to the same word on the same edge return the value held before that write. The new value is visible to a later read.
- R7: With the flag at 1, `seg_n` = {g,f,e,d,c,b,a} active-low shows the digit as 0:7'h40, 1:7'h79, 2:7'h24, 3:7'h30, 4:7'h19, 5:7'h12, 6:7'h02, 7:7'h78.
- R8: With the flag at 0, `seg_n` is 7'h7F whatever the digit register holds. The digit is kept and shows again when the flag returns to 1.
- R9: `seg_n` is registered. It reflects register contents as they stood before the previous clock edge, so a write appears on the pins one edge after the register takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for this peripheral |
| addr | input | 1 | Word address: 0 digit, 1 control |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |

## Verification
The assertions treat the bus strobes as clean levels sampled at each rising edge. They also assume `addr` and `wr_data` are known whenever `cs` is high. They take no handshake for granted: any mix of read, write and chip select on the same edge is legal. For this reason the bench drives all bus inputs only on falling edges and returns the strobes to 0 between transfers. It also applies the simultaneous read-and-write and select-less cases on purpose.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

  localparam int unsigned OFS_DIGIT = 0;
  localparam int unsigned OFS_CTRL  = 1;
  localparam int unsigned SEG_W     = 7;

  // Active-high pattern, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [3:0] val);
    logic [SEG_W-1:0] p;
    case (val)
      4'h0: p = 7'h3F;
      4'h1: p = 7'h06;
      4'h2: p = 7'h5B;
      4'h3: p = 7'h4F;
      4'h4: p = 7'h66;
      4'h5: p = 7'h6D;
      4'h6: p = 7'h7D;
      4'h7: p = 7'h07;
      4'h8: p = 7'h7F;
      4'h9: p = 7'h6F;
      4'hA: p = 7'h77;
      4'hB: p = 7'h7C;
      4'hC: p = 7'h39;
      4'hD: p = 7'h5E;
      4'hE: p = 7'h79;
      default: p = 7'h71;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_disp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DIGIT_W-1:0] digit_q,
  output logic               show_q
);

  logic               wr_en;
  logic [DIGIT_W-1:0] digit_d;
  logic               show_d;
  logic               unused_hi;

  assign wr_en     = cs & wr;
  assign unused_hi = ^wr_data[DATA_W-1:DIGIT_W];

  always_comb begin
    digit_d = digit_q;
    show_d  = show_q;
    if (addr == ADDR_W'(OFS_DIGIT)) digit_d = wr_data[DIGIT_W-1:0];
    if (addr == ADDR_W'(OFS_CTRL))  show_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
      show_q  <= 1'b0;
    end else if (wr_en) begin
      digit_q <= digit_d;
      show_q  <= show_d;
    end
  end

endmodule

// File: rtl/seg_readback.sv
module seg_readback
  import seg_disp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DIGIT_W-1:0] digit_q,
  input  logic               show_q,
  output logic [DATA_W-1:0]  rd_data
);

  logic              rd_en;
  logic [DATA_W-1:0] rd_d;

  assign rd_en = cs & rd;

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(OFS_DIGIT)) rd_d = DATA_W'(digit_q);
      if (addr == ADDR_W'(OFS_CTRL))  rd_d = DATA_W'(show_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_disp_pkg::*;
#(
  parameter int unsigned DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_q,
  input  logic               show_q,
  output logic [SEG_W-1:0]   seg_n
);

  logic [3:0]       idx;
  logic [SEG_W-1:0] seg_d;

  generate
    if (DIGIT_W >= 4) begin : g_wide
      assign idx = digit_q[3:0];
    end else begin : g_narrow
      assign idx = 4'(digit_q);
    end
  endgenerate

  always_comb begin
    if (show_q) seg_d = ~seg_pattern(idx);
    else        seg_d = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_n <= '1;
    else        seg_n <= seg_d;
  end

endmodule

// File: rtl/seg_display_ctrl.sv
module seg_display_ctrl
  import seg_disp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned DIGIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEG_W-1:0]  seg_n
);

  logic [DIGIT_W-1:0] digit_q;
  logic               show_q;

  seg_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIGIT_W(DIGIT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr),
    .wr_data(wr_data), .digit_q(digit_q), .show_q(show_q)
  );

  seg_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIGIT_W(DIGIT_W)) rdbk_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .addr(addr),
    .digit_q(digit_q), .show_q(show_q), .rd_data(rd_data)
  );

  seg_decoder #(.DIGIT_W(DIGIT_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .digit_q(digit_q), .show_q(show_q), .seg_n(seg_n)
  );

endmodule

// File: rtl/seg_display_chk.sv
module seg_display_chk
  import seg_disp_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 1,
  parameter int unsigned DIGIT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs,
  input logic [ADDR_W-1:0]  addr,
  input logic               rd,
  input logic               wr,
  input logic [DATA_W-1:0]  wr_data,
  input logic [DATA_W-1:0]  rd_data,
  input logic [SEG_W-1:0]   seg_n,
  input logic [DIGIT_W-1:0] digit_q,
  input logic               show_q
);

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr) |=> ($stable(digit_q) && $stable(show_q)));

  assert_digit_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == ADDR_W'(OFS_DIGIT)) |=> (digit_q == $past(wr_data[DIGIT_W-1:0])));

  assert_flag_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == ADDR_W'(OFS_CTRL)) |=> (show_q == $past(wr_data[0])));

  assert_read_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[DATA_W-1:DIGIT_W] == '0));

  assert_idle_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> (rd_data == '0));

  assert_shown_lit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    show_q |=> (seg_n != '1));

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !show_q |=> (seg_n == '1));

endmodule

bind seg_display_ctrl seg_display_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIGIT_W(DIGIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
  .wr_data(wr_data), .rd_data(rd_data), .seg_n(seg_n),
  .digit_q(digit_q), .show_q(show_q)
);

// File: tb/seg_display_ctrl_tb.sv
`timescale 1ns/1ps
module seg_display_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cs;
  logic [0:0]  addr;
  logic        rd;
  logic        wr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [6:0]  seg_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  seg_display_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wr_data(wr_data), .rd_data(rd_data), .seg_n(seg_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write data, expected active-low segments}
  localparam int NV = 10;
  localparam logic [38:0] VEC [NV] = '{
    {32'h0000_0000, 7'h40}, {32'h0000_0001, 7'h79},
    {32'h0000_0002, 7'h24}, {32'h0000_0003, 7'h30},
    {32'h0000_0004, 7'h19}, {32'h0000_0005, 7'h12},
    {32'h0000_0006, 7'h02}, {32'h0000_0007, 7'h78},
    {32'hFFFF_FFFD, 7'h12}, {32'hA5A5_A5F8, 7'h40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    d = rd_data;
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    cs = 0; rd = 0; wr = 0; addr = 0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 seg", {25'd0, seg_n}, 32'h7F);
    check("R1 rd_data", rd_data, 32'h0);
    bus_read(1'b0, r); check("R1 digit reg", r, 32'h0);
    bus_read(1'b1, r); check("R1 ctrl reg", r, 32'h0);

    // R7 R3 R4 table walk
    bus_write(1'b1, 32'h0000_0001);
    for (int i = 0; i < NV; i++) begin
      bus_write(1'b0, VEC[i][38:7]);
      @(negedge clk);
      check("R7 segments", {25'd0, seg_n}, {25'd0, VEC[i][6:0]});
      bus_read(1'b0, r);
      check("R3 R4 digit readback", r, {29'd0, VEC[i][9:7]});
    end
    bus_read(1'b1, r); check("R4 ctrl readback", r, 32'h1);

    // R5 idle read data
    @(negedge clk); check("R5 idle rd_data", rd_data, 32'h0);

    // R2 write without chip select
    bus_write(1'b0, 32'h0000_0003);  // digit 3 shown
    @(negedge clk);
    wr = 1'b1; addr = 1'b0; wr_data = 32'h0000_0006;
    @(negedge clk);
    wr = 1'b0; addr = 1'b1; wr_data = 32'h0;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    check("R2 seg unchanged", {25'd0, seg_n}, 32'h30);
    bus_read(1'b0, r); check("R2 digit unchanged", r, 32'h3);
    bus_read(1'b1, r); check("R2 flag unchanged", r, 32'h1);
    // read strobe without select
    @(negedge clk); rd = 1'b1; addr = 1'b0;
    @(negedge clk); check("R5 read without cs", rd_data, 32'h0); rd = 1'b0;

    // R9 latency of the segment register
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = 1'b0; wr_data = 32'h5;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    check("R9 seg one edge late", {25'd0, seg_n}, 32'h30);
    @(negedge clk);
    check("R9 seg updated", {25'd0, seg_n}, 32'h12);

    // R6 read and write same word same edge
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b1; addr = 1'b0; wr_data = 32'h2;
    @(negedge clk);
    check("R6 old value read", rd_data, 32'h5);
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    bus_read(1'b0, r); check("R6 new value later", r, 32'h2);

    // R8 blanking with upper bits set, digit retained
    bus_write(1'b1, 32'hFFFF_FFFE);
    @(negedge clk);
    check("R8 blanked", {25'd0, seg_n}, 32'h7F);
    bus_read(1'b1, r); check("R8 flag cleared", r, 32'h0);
    bus_read(1'b0, r); check("R8 digit kept", r, 32'h2);
    bus_write(1'b0, 32'h7);
    @(negedge clk);
    check("R8 blank ignores digit", {25'd0, seg_n}, 32'h7F);
    bus_write(1'b1, 32'h1);
    @(negedge clk);
    check("R8 shows again", {25'd0, seg_n}, 32'h78);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 seg after reset", {25'd0, seg_n}, 32'h7F);
    bus_read(1'b0, r); check("R1 digit after reset", r, 32'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule